// File: doc/BRIEF.md
# Indirect Buffer Access Register Block

This block sits on the 8-bit microcontroller side of a network controller. It gives the host indirect access to a 2048-byte on-chip buffer RAM. The host never addresses the RAM directly. It loads an 11-bit pointer through two pointer registers, then moves bytes through a single data port. The pointer-high register also fixes the direction of the coming data-port accesses and decides whether the pointer steps after each access. This lets a whole packet be streamed through one register address.

In read mode, loading the low pointer byte starts a fetch of the addressed byte into a holding register, so the first data-port read already returns valid data. Each stepping read fetches the next byte. A single register address is banked across five identity and setup registers. A 3-bit sub-address picks which one it reaches. The low two sub-address bits are also visible in the configuration register. That register additionally carries a software reset bit and a command-chaining enable bit.

Top module: `hostRegIf`

## Requirements
- R1: After the hardware reset (rstN low), every readable register reads 0x00, and swResetOut, chainEnOut and nodeIdOut are 0.
- R2: Writing data-port address 4 while pointer-high bit 7 is 0 (write mode) stores the byte at the RAM location formed by pointer-high bits 2..0 as address bits 10..8 and pointer-low (address 3) bits 7..0 as address bits 7..0.
- R3: With pointer-high bit 6 set, the 11-bit pointer advances by exactly one after each data-port access in the current direction. With bit 6 clear, the pointer holds, so repeated writes land on one location and repeated reads return one byte.
- R4: In read mode (pointer-high bit 7 = 1), a write to pointer-low prefetches the addressed byte, so the next data-port read returns it. With auto-increment, successive reads return consecutive bytes.
- R5: Auto-increment from address 2047 wraps the pointer to address 0.
- R6: A data-port write while in read mode changes neither the RAM nor the pointer.
- R7: Register address 7 reaches one of five registers selected by the sub-address register (address 5, bits 2..0): 0 tentative ID, 1 node ID, 2 setup A, 3 next ID, 4 setup B. Each register holds its own value. The node ID drives nodeIdOut.
- R8: Sub-address values 5 to 7 read 0x00 at address 7, and writes through them change none of the five registers.
- R9: Configuration (address 0) bits 1..0 and sub-address bits 1..0 are one storage: a write to either is visible in the other. Every configuration write clears sub-address bit 2.
- R10: While configuration bit 7 is 1, the next ID register reads 0x00 and ignores writes. After bit 7 is written back to 0, it stays 0x00 until written. Other banked registers and the configuration register are unaffected.
- R11: swResetOut follows configuration bit 7 and chainEnOut follows configuration bit 6, both from the cycle after the write.
- R12: Pointer-high reads back direction in bit 7, auto-increment in bit 6 and address bits 10..8 in bits 2..0, with bits 5..3 reading 0. Addresses 1 and 6 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| busAddr | input | 3 | Host register address |
| busWr | input | 1 | Host write strobe, one cycle per access |
| busRd | input | 1 | Host read strobe, one cycle per access |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Host read data, combinational from busAddr |
| swResetOut | output | 1 | Software reset level to the protocol engine |
| chainEnOut | output | 1 | Command-chaining enable to the protocol engine |
| nodeIdOut | output | 8 | Node ID register value |

## Verification
A pointer that steps wrongly, skips the wrap, or moves on an ignored access shows up at the ports when the pointer bytes are read back, and as a wrong byte on the following data-port read. A missing or late prefetch makes the first read after a pointer-low write return a stale holding value, so it is seen on the very next access. Errors in the sub-address aliasing or the bank decode appear as a wrong value at address 7 or in the low configuration bits on the next read. A software reset that fails to clear the next ID register is visible at address 7 one access after the configuration write.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  localparam logic [2:0] ADDR_CFG   = 3'd0;
  localparam logic [2:0] ADDR_PTRHI = 3'd2;
  localparam logic [2:0] ADDR_PTRLO = 3'd3;
  localparam logic [2:0] ADDR_DATA  = 3'd4;
  localparam logic [2:0] ADDR_SUB   = 3'd5;
  localparam logic [2:0] ADDR_BANK  = 3'd7;

  localparam int BANK_COUNT  = 5;
  localparam int BANK_NODEID = 1;
  localparam int BANK_NEXTID = 3;

  typedef struct packed {
    logic wrCfg;
    logic wrPtrHi;
    logic wrPtrLo;
    logic wrSub;
    logic wrBank;
    logic memWr;
    logic stepPtr;
    logic loadHold;
  } strobeT;

endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic       readMode,
  input  logic       autoInc,
  output strobeT     stb
);

  logic prefetchReq;
  logic pendQ;
  logic dataWr;
  logic dataRd;

  assign dataWr = busWr && (busAddr == ADDR_DATA);
  assign dataRd = busRd && (busAddr == ADDR_DATA);

  assign prefetchReq = readMode &&
                       ((busWr && (busAddr == ADDR_PTRLO)) || (dataRd && autoInc));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= prefetchReq;
  end

  always_comb begin
    stb          = '0;
    stb.wrCfg    = busWr && (busAddr == ADDR_CFG);
    stb.wrPtrHi  = busWr && (busAddr == ADDR_PTRHI);
    stb.wrPtrLo  = busWr && (busAddr == ADDR_PTRLO);
    stb.wrSub    = busWr && (busAddr == ADDR_SUB);
    stb.wrBank   = busWr && (busAddr == ADDR_BANK);
    stb.memWr    = dataWr && !readMode;
    stb.stepPtr  = autoInc && ((dataWr && !readMode) || (dataRd && readMode));
    stb.loadHold = pendQ;
  end

  // R4
  prefetch_after_ptrlo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_PTRLO) && readMode) |=> stb.loadHold);

  // R6
  no_mem_write_in_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readMode && busWr && (busAddr == ADDR_DATA)) |-> (!stb.memWr && !stb.stepPtr));

endmodule

// File: rtl/hostRegDatapath.sv
module hostRegDatapath
  import hostRegPkg::*;
#(
  parameter int ADDR_W = 11
)(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     stb,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  output logic       readMode,
  output logic       autoInc,
  output logic       swReset,
  output logic       chainEn,
  output logic [7:0] nodeId
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic              cfgRst;
  logic              cfgChain;
  logic [2:0]        subSel;
  logic              dirRead;
  logic              stepEn;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        hold;
  logic [7:0]        bankReg [BANK_COUNT];
  logic [7:0]        mem [DEPTH];
  logic [7:0]        bankRd;
  logic [7:0]        ptrHiRd;

  // configuration, sub-address and mode bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRst   <= 1'b0;
      cfgChain <= 1'b0;
      subSel   <= 3'd0;
      dirRead  <= 1'b0;
      stepEn   <= 1'b0;
    end else begin
      if (stb.wrCfg) begin
        cfgRst      <= wrData[7];
        cfgChain    <= wrData[6];
        subSel[1:0] <= wrData[1:0];
        subSel[2]   <= 1'b0;
      end else if (stb.wrSub) begin
        subSel <= wrData[2:0];
      end
      if (stb.wrPtrHi) begin
        dirRead <= wrData[7];
        stepEn  <= wrData[6];
      end
    end
  end

  // address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptr <= '0;
    else if (stb.wrPtrHi)    ptr[ADDR_W-1:8] <= wrData[HI_W-1:0];
    else if (stb.wrPtrLo)    ptr[7:0] <= wrData;
    else if (stb.stepPtr)    ptr <= ptr + ADDR_W'(1);
  end

  // buffer RAM
  always_ff @(posedge clk) begin
    if (stb.memWr) mem[ptr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             hold <= '0;
    else if (stb.loadHold) hold <= mem[ptr];
  end

  // banked identity and setup registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BANK_COUNT; b++) bankReg[b] <= '0;
    end else begin
      for (int b = 0; b < BANK_COUNT; b++) begin
        if (b == BANK_NEXTID && cfgRst)
          bankReg[b] <= '0;
        else if (stb.wrBank && (subSel == 3'(b)))
          bankReg[b] <= wrData;
      end
    end
  end

  always_comb begin
    bankRd = '0;
    for (int b = 0; b < BANK_COUNT; b++)
      if (subSel == 3'(b)) bankRd = bankReg[b];
  end

  always_comb begin
    ptrHiRd           = '0;
    ptrHiRd[7]        = dirRead;
    ptrHiRd[6]        = stepEn;
    ptrHiRd[HI_W-1:0] = ptr[ADDR_W-1:8];
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CFG:   rdData = {cfgRst, cfgChain, 4'b0000, subSel[1:0]};
      ADDR_PTRHI: rdData = ptrHiRd;
      ADDR_PTRLO: rdData = ptr[7:0];
      ADDR_DATA:  rdData = hold;
      ADDR_SUB:   rdData = {5'b00000, subSel};
      ADDR_BANK:  rdData = bankRd;
      default:    rdData = 8'h00;
    endcase
  end

  assign readMode = dirRead;
  assign autoInc  = stepEn;
  assign swReset  = cfgRst;
  assign chainEn  = cfgChain;
  assign nodeId   = bankReg[BANK_NODEID];

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepPtr && !stb.wrPtrHi && !stb.wrPtrLo) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepPtr && !stb.wrPtrHi && !stb.wrPtrLo) |=> $stable(ptr));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepPtr && !stb.wrPtrHi && !stb.wrPtrLo && (ptr == '1)) |=> (ptr == '0));

  // R9
  sub_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCfg |=> (subSel == {1'b0, $past(wrData[1:0])}));

  // R10
  next_id_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRst |=> (bankReg[BANK_NEXTID] == 8'h00));

endmodule

// File: rtl/hostRegIf.sv
module hostRegIf
  import hostRegPkg::*;
#(
  parameter int ADDR_W = 11
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       swResetOut,
  output logic       chainEnOut,
  output logic [7:0] nodeIdOut
);

  strobeT stb;
  logic   readMode;
  logic   autoInc;

  hostRegCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .readMode (readMode),
    .autoInc  (autoInc),
    .stb      (stb)
  );

  hostRegDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (busWrData),
    .rdAddr   (busAddr),
    .rdData   (busRdData),
    .readMode (readMode),
    .autoInc  (autoInc),
    .swReset  (swResetOut),
    .chainEn  (chainEnOut),
    .nodeId   (nodeIdOut)
  );

endmodule

// File: tb/test_hostRegIf.sv
module test_hostRegIf;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       swResetOut;
  logic       chainEnOut;
  logic [7:0] nodeIdOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  localparam logic [2:0] CFG = 3'd0, PHI = 3'd2, PLO = 3'd3, DAT = 3'd4, SUB = 3'd5, BNK = 3'd7;

  always #2 clk = ~clk;

  hostRegIf i_hostRegIf (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .swResetOut(swResetOut),
    .chainEnOut(chainEnOut), .nodeIdOut(nodeIdOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(posedge clk);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(CFG, v); check("R1 cfg", v, 8'h00);
    rd(PHI, v); check("R1 ptrHi", v, 8'h00);
    rd(PLO, v); check("R1 ptrLo", v, 8'h00);
    rd(SUB, v); check("R1 sub", v, 8'h00);
    rd(BNK, v); check("R1 bank", v, 8'h00);
    check("R1 outputs", {6'd0, swResetOut, chainEnOut}, 8'h00);
    check("R1 nodeId", nodeIdOut, 8'h00);
  endtask

  task automatic t_burst();
    logic [7:0] v;
    wr(PHI, 8'h41); wr(PLO, 8'h10);
    for (int i = 0; i < 4; i++) wr(DAT, 8'hA0 + 8'(i));
    rd(PLO, v); check("R3 ptr after 4 writes", v, 8'h14);
    wr(PHI, 8'hC1); wr(PLO, 8'h10);
    for (int i = 0; i < 4; i++) begin
      rd(DAT, v); check("R2 R4 burst read", v, 8'hA0 + 8'(i));
    end
    rd(PLO, v); check("R3 ptr after 4 reads", v, 8'h14);
  endtask

  task automatic t_noInc();
    logic [7:0] v;
    wr(PHI, 8'h02); wr(PLO, 8'h20);
    wr(DAT, 8'h11); wr(DAT, 8'h22);
    rd(PLO, v); check("R3 hold on write", v, 8'h20);
    wr(PHI, 8'h82); wr(PLO, 8'h20);
    rd(DAT, v); check("R3 no-inc read 1", v, 8'h22);
    rd(DAT, v); check("R3 no-inc read 2", v, 8'h22);
    rd(PLO, v); check("R3 hold on read", v, 8'h20);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr(PHI, 8'h47); wr(PLO, 8'hFF);
    wr(DAT, 8'h5A); wr(DAT, 8'h6B);
    rd(PHI, v); check("R5 ptrHi after wrap", v, 8'h40);
    rd(PLO, v); check("R5 ptrLo after wrap", v, 8'h01);
    wr(PHI, 8'hC7); wr(PLO, 8'hFF);
    rd(DAT, v); check("R5 byte 2047", v, 8'h5A);
    rd(DAT, v); check("R5 byte 0 after wrap", v, 8'h6B);
  endtask

  task automatic t_dirIgnore();
    logic [7:0] v;
    wr(PHI, 8'h00); wr(PLO, 8'h30); wr(DAT, 8'h77);
    wr(PHI, 8'hC0); wr(PLO, 8'h30);
    wr(DAT, 8'hEE);
    rd(PLO, v); check("R6 ptr unchanged", v, 8'h30);
    wr(PLO, 8'h30);
    rd(DAT, v); check("R6 ram unchanged", v, 8'h77);
  endtask

  task automatic t_bank();
    logic [7:0] v;
    for (int i = 0; i < 5; i++) begin
      wr(SUB, 8'(i)); wr(BNK, 8'h10 * 8'(i + 1));
    end
    for (int i = 0; i < 5; i++) begin
      wr(SUB, 8'(i)); rd(BNK, v); check("R7 bank readback", v, 8'h10 * 8'(i + 1));
    end
    check("R7 nodeIdOut", nodeIdOut, 8'h20);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    for (int i = 5; i < 8; i++) begin
      wr(SUB, 8'(i)); wr(BNK, 8'h99); rd(BNK, v); check("R8 reserved reads zero", v, 8'h00);
    end
    for (int i = 0; i < 5; i++) begin
      wr(SUB, 8'(i)); rd(BNK, v); check("R8 banks untouched", v, 8'h10 * 8'(i + 1));
    end
  endtask

  task automatic t_alias();
    logic [7:0] v;
    wr(SUB, 8'h04);
    wr(CFG, 8'h03);
    rd(SUB, v); check("R9 cfg write clears sub bit 2", v, 8'h03);
    wr(SUB, 8'h06);
    rd(CFG, v); check("R9 sub visible in cfg", v, 8'h02);
  endtask

  task automatic t_softReset();
    logic [7:0] v;
    wr(CFG, 8'h83);
    check("R11 swResetOut set", {7'd0, swResetOut}, 8'h01);
    rd(BNK, v); check("R10 next id cleared", v, 8'h00);
    wr(BNK, 8'h55);
    rd(BNK, v); check("R10 write ignored in reset", v, 8'h00);
    rd(CFG, v); check("R10 cfg kept", v, 8'h83);
    wr(CFG, 8'h03);
    check("R11 swResetOut released", {7'd0, swResetOut}, 8'h00);
    rd(BNK, v); check("R10 stays zero", v, 8'h00);
    check("R10 nodeId kept", nodeIdOut, 8'h20);
    wr(BNK, 8'h66);
    rd(BNK, v); check("R10 writable again", v, 8'h66);
  endtask

  task automatic t_chain();
    logic [7:0] v;
    wr(CFG, 8'h40);
    check("R11 chainEnOut set", {7'd0, chainEnOut}, 8'h01);
    rd(CFG, v); check("R11 cfg chain bit", v, 8'h40);
    wr(CFG, 8'h00);
    check("R11 chainEnOut clear", {7'd0, chainEnOut}, 8'h00);
  endtask

  task automatic t_ptrRead();
    logic [7:0] v;
    wr(PHI, 8'hFF);
    rd(PHI, v); check("R12 ptrHi reserved bits", v, 8'hC7);
    rd(3'd1, v); check("R12 addr 1 reads zero", v, 8'h00);
    rd(3'd6, v); check("R12 addr 6 reads zero", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_burst();
    t_noInc();
    t_wrap();
    t_dirIgnore();
    t_bank();
    t_reserved();
    t_alias();
    t_softReset();
    t_chain();
    t_ptrRead();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule